// File: doc/BRIEF.md
# Paired-Channel Routing Switch Matrix

This block is one routing switch in a grid of logic tiles. Each of its four sides (north, east, south, west) has eight wire channels. Four are short wires that run to the neighbouring switch. Four are long wires that skip one switch and reach the one two positions away. Every wire is modelled as a separate input and output, so the fabric contains no tristate nets. A route may only join wires that share a channel number on different sides. Short channel p is tied to long channel p, and together they form pair p. A net therefore stays on one pair from source to sink, and a router needs only a very simple search.

Each output wire has its own 3-bit source selector. The selector can leave the wire undriven, at logic 0. It can pick the same-kind wire with the same index from another side, or the partner-kind wire of the same pair from the opposite side. On the south short wires it can also pick one of the four outputs of the attached logic tile. The six inputs of the tile are each chosen from the eight wires arriving on the south side. All selectors make up one configuration word. That word is shifted in serially and applied in a single cycle by a load strobe, so the wires never see a half-written configuration.

Top module: `pair_switch_matrix`

## Requirements
- R1: While reset is high, both the shadow and the active configuration are cleared. After reset, every short and long output is 0, and every tile input follows the south short wire of pair 0.
- R2: Wire indices are side*4+pair, with sides N=0, E=1, S=2, W=3. Selector codes 1, 2, 3 and 4 drive an output from the same-kind wire with the same pair index arriving on side N, E, S or W respectively.
- R3: A code 1 to 4 that names the output's own side is illegal. The output then drives 0.
- R4: Codes 0 and 7 leave the output undriven, and it drives 0.
- R5: Code 5 drives an output from the wire of the other kind (long for a short output, short for a long output) of the same pair, arriving on the opposite side.
- R6: Code 6 on a south short output of pair p drives tile output p onto it. On any other output, code 6 drives 0.
- R7: Tile input i takes the south wire picked by its 3-bit code c. Codes 0 to 3 pick short pair c, and codes 4 to 7 pick long pair c-4.
- R8: The configuration word is 114 bits long. The output selector for side s, pair p, kind k (short=0, long=1) sits at bits 3f+2..3f, where f=(s*4+p)*2+k. Tile-input selector i sits at bits 96+3i+2..96+3i. When shift is enabled, each clock moves the word one place toward the MSB and the serial bit enters bit 0, so the MSB is sent first.
- R9: Shifting without a load strobe never changes any output. The active configuration changes only on a clock edge where load is high.
- R10: When load and shift are both high on the same edge, the active configuration takes the shadow word as it was before that edge's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift one configuration bit in |
| cfg_sdi | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copy shadow word into active configuration |
| sh_in | input | 16 | Arriving short wires, index side*4+pair |
| lg_in | input | 16 | Arriving long wires, index side*4+pair |
| blk_drive | input | 4 | Outputs of the attached logic tile |
| sh_out | output | 16 | Departing short wires |
| lg_out | output | 16 | Departing long wires |
| blk_feed | output | 6 | Inputs of the attached logic tile |

## Verification
The routing is tried with uniform configurations in which every output uses the same code: all own-side, all partner, all tile-injection and all none. These separate the illegal-side rule, the kind swap across opposite sides and the south-only injection from ordinary same-channel routing. Fully random configurations with random wire values then mix all codes, so a wrong side index or a swapped pair shows up on some output. Short directed words with one selector at each end of the chain pin down the bit layout. The bench also holds the wires constant while a complete word is shifted without a load, which shows that shifting alone cannot disturb the outputs. Finally, a load strobe raised in the middle of a shift shows which shadow value the load captures.

// File: rtl/psm_pkg.sv
package psm_pkg;

    localparam int SIDES      = 4;
    localparam int SIDE_W     = $clog2(SIDES);
    localparam int SEL_W      = 3;
    localparam int KIND_SHORT = 0;
    localparam int KIND_LONG  = 1;

    // Source selector code for one departing wire.
    typedef enum logic [SEL_W-1:0] {
        SRC_NONE    = 3'd0,
        SRC_N       = 3'd1,
        SRC_E       = 3'd2,
        SRC_S       = 3'd3,
        SRC_W       = 3'd4,
        SRC_PARTNER = 3'd5,
        SRC_BLOCK   = 3'd6,
        SRC_OFF     = 3'd7
    } src_sel_e;

    function automatic int opposite_side(input int side);
        return (side + SIDES / 2) % SIDES;
    endfunction

    function automatic int field_index(input int side, input int pair, input int kind,
                                       input int pairs);
        return (side * pairs + pair) * 2 + kind;
    endfunction

endpackage

// File: rtl/psm_cfg_chain.sv
module psm_cfg_chain #(
    parameter int CFG_BITS = 114
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                sdi,
    input  logic                load,
    output logic [CFG_BITS-1:0] shadow_q,
    output logic [CFG_BITS-1:0] active_q
);

    // The shadow word shifts toward the MSB. The active word copies the
    // pre-shift shadow only on a load edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (shift_en)
                shadow_q <= {shadow_q[CFG_BITS-2:0], sdi};
            if (load)
                active_q <= shadow_q;
        end
    end

endmodule

// File: rtl/psm_wire_mux.sv
module psm_wire_mux
    import psm_pkg::*;
#(
    parameter int OWN_SIDE = 0
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [SIDES-1:0] same_kind_i,
    input  logic             partner_i,
    input  logic             block_i,
    output logic             wire_o
);

    logic [SIDE_W-1:0] src_side;
    src_sel_e          code;

    assign code     = src_sel_e'(sel_i);
    assign src_side = sel_i[SIDE_W-1:0] - SIDE_W'(1);

    always_comb begin
        wire_o = 1'b0;
        unique case (code)
            SRC_N, SRC_E, SRC_S, SRC_W: begin
                if (src_side != SIDE_W'(OWN_SIDE))
                    wire_o = same_kind_i[src_side];
            end
            SRC_PARTNER: wire_o = partner_i;
            SRC_BLOCK:   wire_o = block_i;
            SRC_NONE, SRC_OFF: wire_o = 1'b0;
            default:     wire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/psm_blk_port.sv
module psm_blk_port #(
    parameter int PAIRS   = 4,
    parameter int BLK_INS = 6,
    parameter int BSEL_W  = 3
) (
    input  logic [2*PAIRS-1:0]        side_wires_i,
    input  logic [BLK_INS*BSEL_W-1:0] sel_i,
    output logic [BLK_INS-1:0]        feed_o
);

    for (genvar gi = 0; gi < BLK_INS; gi++) begin : g_feed
        assign feed_o[gi] = side_wires_i[sel_i[gi*BSEL_W +: BSEL_W]];
    end

endmodule

// File: rtl/pair_switch_matrix.sv
module pair_switch_matrix
    import psm_pkg::*;
#(
    parameter int PAIRS    = 4,
    parameter int BLK_OUTS = 4,
    parameter int BLK_INS  = 6,
    parameter int BLK_SIDE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_shift_en,
    input  logic                     cfg_sdi,
    input  logic                     cfg_load,
    input  logic [SIDES*PAIRS-1:0]   sh_in,
    input  logic [SIDES*PAIRS-1:0]   lg_in,
    input  logic [BLK_OUTS-1:0]      blk_drive,
    output logic [SIDES*PAIRS-1:0]   sh_out,
    output logic [SIDES*PAIRS-1:0]   lg_out,
    output logic [BLK_INS-1:0]       blk_feed
);

    localparam int NW         = SIDES * PAIRS;
    localparam int OUT_FIELDS = NW * 2;
    localparam int BSEL_W     = $clog2(2 * PAIRS);
    localparam int OUT_BITS   = OUT_FIELDS * SEL_W;
    localparam int CFG_BITS   = OUT_BITS + BLK_INS * BSEL_W;

    logic [CFG_BITS-1:0] shadow_q;
    logic [CFG_BITS-1:0] active_q;

    psm_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_shift_en),
        .sdi      (cfg_sdi),
        .load     (cfg_load),
        .shadow_q (shadow_q),
        .active_q (active_q)
    );

    for (genvar gs = 0; gs < SIDES; gs++) begin : g_side
        localparam int OPP = opposite_side(gs);
        for (genvar gp = 0; gp < PAIRS; gp++) begin : g_pair
            for (genvar gk = 0; gk < 2; gk++) begin : g_kind
                localparam int F = field_index(gs, gp, gk, PAIRS);
                logic [SIDES-1:0] same_v;
                logic             partner_w;
                logic             inject_w;
                logic             wire_w;

                for (genvar gg = 0; gg < SIDES; gg++) begin : g_same
                    if (gk == KIND_LONG) begin : g_l
                        assign same_v[gg] = lg_in[gg*PAIRS+gp];
                    end else begin : g_s
                        assign same_v[gg] = sh_in[gg*PAIRS+gp];
                    end
                end

                if (gk == KIND_LONG) begin : g_pl
                    assign partner_w = sh_in[OPP*PAIRS+gp];
                end else begin : g_ps
                    assign partner_w = lg_in[OPP*PAIRS+gp];
                end

                if (gs == BLK_SIDE && gk == KIND_SHORT && gp < BLK_OUTS) begin : g_inj
                    assign inject_w = blk_drive[gp];
                end else begin : g_noinj
                    assign inject_w = 1'b0;
                end

                psm_wire_mux #(.OWN_SIDE(gs)) u_mux (
                    .sel_i       (active_q[F*SEL_W +: SEL_W]),
                    .same_kind_i (same_v),
                    .partner_i   (partner_w),
                    .block_i     (inject_w),
                    .wire_o      (wire_w)
                );

                if (gk == KIND_LONG) begin : g_ol
                    assign lg_out[gs*PAIRS+gp] = wire_w;
                end else begin : g_os
                    assign sh_out[gs*PAIRS+gp] = wire_w;
                end
            end
        end
    end

    psm_blk_port #(
        .PAIRS   (PAIRS),
        .BLK_INS (BLK_INS),
        .BSEL_W  (BSEL_W)
    ) u_blk (
        .side_wires_i ({lg_in[BLK_SIDE*PAIRS +: PAIRS], sh_in[BLK_SIDE*PAIRS +: PAIRS]}),
        .sel_i        (active_q[OUT_BITS +: BLK_INS*BSEL_W]),
        .feed_o       (blk_feed)
    );

endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
    parameter int NW       = 16,
    parameter int BLK_OUTS = 4,
    parameter int BLK_INS  = 6,
    parameter int CFG_BITS = 114
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_shift_en,
    input logic                cfg_sdi,
    input logic                cfg_load,
    input logic [NW-1:0]       sh_in,
    input logic [NW-1:0]       lg_in,
    input logic [BLK_OUTS-1:0] blk_drive,
    input logic [NW-1:0]       sh_out,
    input logic [NW-1:0]       lg_out,
    input logic [BLK_INS-1:0]  blk_feed,
    input logic [CFG_BITS-1:0] shadow_q,
    input logic [CFG_BITS-1:0] active_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (active_q == '0 && sh_out == '0 && lg_out == '0));

    // R8
    shift_moves_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_shift_en |=> shadow_q == {$past(shadow_q[CFG_BITS-2:0]), $past(cfg_sdi)});

    // R9
    hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(active_q));

    // R10
    load_takes_preshift_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> active_q == $past(shadow_q));

    // R9
    outputs_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(sh_in) && $stable(lg_in) && $stable(blk_drive) && $stable(active_q))
        |-> ($stable(sh_out) && $stable(lg_out) && $stable(blk_feed)));

endmodule

bind pair_switch_matrix psm_checker #(
    .NW       (NW),
    .BLK_OUTS (BLK_OUTS),
    .BLK_INS  (BLK_INS),
    .CFG_BITS (CFG_BITS)
) u_psm_chk (.*);

// File: tb/pair_switch_matrix_bench.sv
module pair_switch_matrix_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_shift_en = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] sh_in = '0;
    logic [15:0] lg_in = '0;
    logic [3:0]  blk_drive = '0;
    logic [15:0] sh_out;
    logic [15:0] lg_out;
    logic [5:0]  blk_feed;

    always #5 clk = ~clk;

    pair_switch_matrix u_pair_switch_matrix (
        .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
        .cfg_load(cfg_load), .sh_in(sh_in), .lg_in(lg_in), .blk_drive(blk_drive),
        .sh_out(sh_out), .lg_out(lg_out), .blk_feed(blk_feed)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // Reference model of the configuration state, advanced on every edge.
    logic [113:0] m_sh = '0;
    logic [113:0] m_act = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_sh  = '0;
            m_act = '0;
        end else begin
            if (cfg_load) m_act = m_sh;
            if (cfg_shift_en) m_sh = {m_sh[112:0], cfg_sdi};
        end
    end

    function automatic int code_of(int s, int p, int k);
        int f;
        f = (s * 4 + p) * 2 + k;
        return int'(m_act[3*f +: 3]);
    endfunction

    function automatic logic exp_wire(int s, int p, int k);
        int code;
        int src;
        int opp;
        code = code_of(s, p, k);
        if (code >= 1 && code <= 4) begin
            src = code - 1;
            if (src == s) return 1'b0;
            return k ? lg_in[src*4+p] : sh_in[src*4+p];
        end
        if (code == 5) begin
            opp = (s + 2) % 4;
            return k ? sh_in[opp*4+p] : lg_in[opp*4+p];
        end
        if (code == 6) return (s == 2 && k == 0) ? blk_drive[p] : 1'b0;
        return 1'b0;
    endfunction

    function automatic logic exp_feed(int i);
        int code;
        code = int'(m_act[96+3*i +: 3]);
        return (code < 4) ? sh_in[8+code] : lg_in[8+code-4];
    endfunction

    function automatic string tag_for(int code, int s);
        if (code >= 1 && code <= 4) return (code - 1 == s) ? "R3" : "R2";
        if (code == 5) return "R5";
        if (code == 6) return "R6";
        return "R4";
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string force_tag);
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 2; k++) begin
                    string tg;
                    logic  act;
                    tg  = (force_tag == "") ? tag_for(code_of(s, p, k), s) : force_tag;
                    act = k ? lg_out[s*4+p] : sh_out[s*4+p];
                    check_bit(tg, $sformatf("side %0d pair %0d kind %0d", s, p, k),
                              act, exp_wire(s, p, k));
                end
        for (int i = 0; i < 6; i++)
            check_bit((force_tag == "") ? "R7" : force_tag, $sformatf("feed %0d", i),
                      blk_feed[i], exp_feed(i));
    endtask

    always @(negedge clk) begin
        if (cmp_en && !rst) compare_all("");
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_rand();
        sh_in     = 16'($urandom);
        lg_in     = 16'($urandom);
        blk_drive = 4'($urandom);
    endtask

    task automatic send_cfg(logic [113:0] v, bit rand_wires);
        for (int b = 113; b >= 0; b--) begin
            cfg_shift_en = 1'b1;
            cfg_sdi      = v[b];
            if (rand_wires) drive_rand();
            step();
        end
        cfg_shift_en = 1'b0;
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
    endtask

    task automatic traffic(int n);
        for (int i = 0; i < n; i++) begin
            drive_rand();
            step();
        end
    endtask

    function automatic logic [113:0] rand_word();
        logic [113:0] v;
        for (int b = 0; b < 114; b++) v[b] = 1'($urandom);
        return v;
    endfunction

    function automatic logic [113:0] uniform_word(int mode);
        logic [113:0] v;
        v = rand_word();
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 2; k++) begin
                    int f;
                    f = (s * 4 + p) * 2 + k;
                    if (mode < 0) v[3*f +: 3] = 3'(s + 1);
                    else if (mode == 9) v[3*f +: 3] = 3'(1 + (s + 1 + $urandom_range(0, 2)) % 4);
                    else v[3*f +: 3] = 3'(mode);
                end
        return v;
    endfunction

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [113:0] v;
        logic [15:0]  keep_sh;
        logic [15:0]  keep_lg;
        logic [5:0]   keep_fd;

        // R1: reset with random wires
        drive_rand();
        repeat (3) step();
        @(negedge clk);
        check_bit("R1", "sh_out in reset", |sh_out, 1'b0);
        check_bit("R1", "lg_out in reset", |lg_out, 1'b0);
        check_bit("R1", "feed in reset", blk_feed == {6{sh_in[8]}}, 1'b1);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1", "sh_out after reset", |sh_out, 1'b0);
        check_bit("R1", "feed after reset", blk_feed == {6{sh_in[8]}}, 1'b1);
        cmp_en = 1'b1;

        // R8: selectors at both ends of the chain
        v = '0;
        v[2:0]     = 3'd3;   // N pair0 short from S
        v[95:93]   = 3'd1;   // W pair3 long from N
        v[113:111] = 3'd7;   // feed 5 from long pair3
        send_cfg(v, 1'b1);
        pulse_load();
        drive_rand();
        @(negedge clk);
        check_bit("R8", "first field", sh_out[0], sh_in[8]);
        check_bit("R8", "last output field", lg_out[15], lg_in[3]);
        check_bit("R8", "last feed field", blk_feed[5], lg_in[11]);
        step();

        // R3: every output names its own side
        send_cfg(uniform_word(-1), 1'b1);
        pulse_load();
        traffic(6);
        @(negedge clk);
        compare_all("R3");
        step();

        // R5, R6, R4: uniform codes
        send_cfg(uniform_word(5), 1'b0);
        pulse_load();
        traffic(6);
        @(negedge clk);
        compare_all("R5");
        step();
        send_cfg(uniform_word(6), 1'b0);
        pulse_load();
        traffic(6);
        @(negedge clk);
        compare_all("R6");
        step();
        send_cfg(uniform_word(7), 1'b0);
        pulse_load();
        traffic(4);
        send_cfg(uniform_word(0), 1'b0);
        pulse_load();
        traffic(4);
        @(negedge clk);
        compare_all("R4");
        step();

        // R2: legal other-side sources only
        send_cfg(uniform_word(9), 1'b1);
        pulse_load();
        traffic(8);
        @(negedge clk);
        compare_all("R2");
        step();

        // R9: full shift without load, wires held
        drive_rand();
        @(negedge clk);
        keep_sh = sh_out;
        keep_lg = lg_out;
        keep_fd = blk_feed;
        step();
        send_cfg(rand_word(), 1'b0);
        @(negedge clk);
        check_bit("R9", "sh_out after shift", sh_out == keep_sh, 1'b1);
        check_bit("R9", "lg_out after shift", lg_out == keep_lg, 1'b1);
        check_bit("R9", "feed after shift", blk_feed == keep_fd, 1'b1);
        step();

        // R10: load raised during a shift
        v = rand_word();
        for (int b = 113; b >= 0; b--) begin
            cfg_shift_en = 1'b1;
            cfg_sdi      = v[b];
            cfg_load     = (b == 53);
            drive_rand();
            step();
            if (b == 53) begin
                @(negedge clk);
                compare_all("R10");
            end
        end
        cfg_shift_en = 1'b0;
        cfg_load     = 1'b0;
        traffic(3);

        // Random configurations, R2 through R7 mixed
        for (int n = 0; n < 20; n++) begin
            send_cfg(rand_word(), 1'b1);
            pulse_load();
            traffic(12);
        end

        @(negedge clk);
        cmp_en = 1'b0;
        finish_run();
    end

endmodule